// File: doc/BRIEF.md
# Flash program/erase sequencer

This block sits between an 8-bit CPU's data-write path and an on-chip flash array. It turns a one-cycle write or erase request into a self-timed cell operation. It checks the software enable bits in a small control word before it accepts a request. A cycle counter measures the operation's duration. The CPU is held by a stall output for the whole operation. Interrupt events that arrive in that time are kept and passed on once the operation ends.

A write changes one byte and can only clear bits: the value committed is the bitwise AND of the stored byte and the new byte. An erase returns a whole sector to all ones. A 512-byte sector is erased in the main array, or all 128 bytes when the request targets the scratchpad. A mode bit makes the lowest 128 data addresses reach a separate scratchpad sector. That sector holds data only, and an instruction fetch from it is flagged as a fault.

The cell array itself lies outside the block. The block drives an address, a sector-select line, write data and one-cycle write or erase strobes, and it reads back the stored byte.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After an accepted request, `busy` and `stall` are both high for exactly WRITE_CYCLES cycles (write) or ERASE_CYCLES cycles (erase), beginning the cycle after the request. At all other times both are low.
- R2: A write is committed by a single-cycle `fl_we` pulse in the last busy cycle. Afterwards the byte reads back on `cpu_rdata` at the same address.
- R3: A write request is accepted only when `prog_ctl[0]`=1. An erase request is accepted only when `prog_ctl[1]`=1. A rejected request raises no `busy` and leaves the array unchanged.
- R4: An erase of the main array clears the whole 512-byte sector that holds the request address, and `fl_addr` carries that address with its low 9 bits cleared. Other sectors keep their contents.
- R5: A write stores the bitwise AND of the stored byte and the new byte, so no bit goes from 0 to 1.
- R6: With `prog_ctl[2]`=1, data addresses 0x00–0x7F select the scratchpad: `fl_scratch`=1 and the low 7 address bits are used. Addresses from 0x80 up, or any address with `prog_ctl[2]`=0, select the main array. This applies to reads, writes and erases.
- R7: An erase that targets the scratchpad clears all 128 scratchpad bytes and leaves the main array unchanged.
- R8: While busy, `irq_out` is all zeros, and each bit of `irq_in` seen high is held. In the first idle cycle the held bits are presented on `irq_out`, ORed with `irq_in`. The held bits are then cleared. When idle, `irq_out` equals `irq_in`.
- R9: A write or erase request that arrives while busy is ignored. The running operation is neither lengthened nor retargeted.
- R10: `fetch_fault` is high in the same cycle when `fetch_valid`=1, `prog_ctl[2]`=1 and `fetch_addr` < 0x80, and is low otherwise.
- R11: After reset the block is idle: `busy`, `stall`, `fl_we`, `fl_erase` and `irq_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_ctl | input | 3 | bit0 write enable, bit1 erase enable, bit2 scratchpad select |
| req_valid | input | 1 | One-cycle write or erase request |
| req_erase | input | 1 | 1 = erase, 0 = byte write |
| cpu_addr | input | 16 | CPU data address for requests and reads |
| req_data | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Data read back from the selected array |
| fetch_valid | input | 1 | Instruction fetch in progress |
| fetch_addr | input | 16 | Fetch address |
| fetch_fault | output | 1 | Fetch aimed at the mapped scratchpad |
| irq_in | input | IRQ_N | Interrupt event pulses |
| irq_out | output | IRQ_N | Interrupt events passed to the CPU |
| stall | output | 1 | CPU hold during an operation |
| busy | output | 1 | Operation in progress |
| fl_addr | output | 16 | Array address (sector base during an erase) |
| fl_scratch | output | 1 | 1 selects the scratchpad sector |
| fl_rdata | input | 8 | Stored byte at fl_addr |
| fl_wdata | output | 8 | Byte to commit |
| fl_we | output | 1 | One-cycle write strobe |
| fl_erase | output | 1 | One-cycle sector erase strobe |

## Verification
A cycle counter with a wrong load value or compare shows up at once as a `busy`/`stall` window of the wrong length. The bench measures that window for every operation. A wrong latched address, or a latched scratchpad-select bit, shows up as a wrong byte when the location is read back in the first idle cycle after the commit. The check also reads neighbouring addresses and the other array to catch a commit or erase that went to the wrong place. A held-interrupt register that leaks or gets lost is visible on `irq_out` within one cycle of `busy` falling.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int FS_AW = 16;
  localparam int FS_DW = 8;

  typedef logic [FS_AW-1:0] faddr_t;
  typedef logic [FS_DW-1:0] fbyte_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2
  } op_state_t;

  // Address lands in the remapped scratchpad window
  function automatic logic scratch_hit(faddr_t a, logic en, int unsigned bytes);
    return en && (a < faddr_t'(bytes));
  endfunction

  // First address of the sector holding a
  function automatic faddr_t sector_base(faddr_t a, int unsigned bytes);
    return a & ~faddr_t'(bytes - 1);
  endfunction

  // Flash cells can only go from 1 to 0
  function automatic fbyte_t clear_only(fbyte_t stored, fbyte_t incoming);
    return stored & incoming;
  endfunction
endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_seq_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 10000,
  parameter int unsigned ERASE_CYCLES = 2400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  output logic busy,
  output logic done,
  output logic is_erase
);
  localparam int unsigned LONGEST = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] ER_LAST = CW'(ERASE_CYCLES - 1);

  op_state_t       st;
  logic [CW-1:0]   remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= OP_IDLE;
      remain <= '0;
    end else begin
      case (st)
        OP_IDLE: begin
          if (start) begin
            st     <= start_erase ? OP_ERASE : OP_WRITE;
            remain <= start_erase ? ER_LAST : WR_LAST;
          end
        end
        default: begin
          if (remain == '0) st <= OP_IDLE;
          else remain <= remain - CW'(1);
        end
      endcase
    end
  end

  assign busy     = (st != OP_IDLE);
  assign is_erase = (st == OP_ERASE);
  assign done     = busy && (remain == '0);
endmodule

// File: rtl/flash_irq_hold.sv
module flash_irq_hold #(
  parameter int unsigned IRQ_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [IRQ_N-1:0] irq_in,
  output logic [IRQ_N-1:0] irq_out
);
  logic [IRQ_N-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (busy) held <= held | irq_in;
    else           held <= '0;
  end

  assign irq_out = busy ? '0 : (held | irq_in);
endmodule

// File: rtl/flash_addr_map.sv
module flash_addr_map
  import flash_seq_pkg::*;
#(
  parameter int unsigned SCRATCH_BYTES = 128
) (
  input  faddr_t addr,
  input  logic   scr_en,
  output logic   hit,
  output faddr_t phys
);
  assign hit  = scratch_hit(addr, scr_en, SCRATCH_BYTES);
  assign phys = hit ? (addr & faddr_t'(SCRATCH_BYTES - 1)) : addr;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES  = 10000,
  parameter int unsigned ERASE_CYCLES  = 2400000,
  parameter int unsigned SECTOR_BYTES  = 512,
  parameter int unsigned SCRATCH_BYTES = 128,
  parameter int unsigned IRQ_N         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       prog_ctl,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic [FS_AW-1:0] cpu_addr,
  input  logic [FS_DW-1:0] req_data,
  output logic [FS_DW-1:0] cpu_rdata,
  input  logic             fetch_valid,
  input  logic [FS_AW-1:0] fetch_addr,
  output logic             fetch_fault,
  input  logic [IRQ_N-1:0] irq_in,
  output logic [IRQ_N-1:0] irq_out,
  output logic             stall,
  output logic             busy,
  output logic [FS_AW-1:0] fl_addr,
  output logic             fl_scratch,
  input  logic [FS_DW-1:0] fl_rdata,
  output logic [FS_DW-1:0] fl_wdata,
  output logic             fl_we,
  output logic             fl_erase
);
  localparam int CTL_WR  = 0;
  localparam int CTL_ER  = 1;
  localparam int CTL_SCR = 2;

  // Named internal events (observed by the bound checker)
  logic   op_start;
  logic   op_done;
  logic   op_erase;
  logic   data_hit;
  faddr_t data_phys;

  faddr_t addr_q;
  fbyte_t data_q;
  logic   scr_q;

  flash_addr_map #(.SCRATCH_BYTES(SCRATCH_BYTES)) u_map (
    .addr   (cpu_addr),
    .scr_en (prog_ctl[CTL_SCR]),
    .hit    (data_hit),
    .phys   (data_phys)
  );

  assign op_start = req_valid && !busy &&
                    (req_erase ? prog_ctl[CTL_ER] : prog_ctl[CTL_WR]);

  flash_op_timer #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (op_start),
    .start_erase (req_erase),
    .busy        (busy),
    .done        (op_done),
    .is_erase    (op_erase)
  );

  flash_irq_hold #(.IRQ_N(IRQ_N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      scr_q  <= 1'b0;
    end else if (op_start) begin
      addr_q <= data_phys;
      data_q <= req_data;
      scr_q  <= data_hit;
    end
  end

  always_comb begin
    if (!busy) begin
      fl_addr    = data_phys;
      fl_scratch = data_hit;
    end else begin
      fl_scratch = scr_q;
      if (!op_erase)  fl_addr = addr_q;
      else if (scr_q) fl_addr = '0;
      else            fl_addr = sector_base(addr_q, SECTOR_BYTES);
    end
  end

  assign stall       = busy;
  assign fl_we       = op_done && !op_erase;
  assign fl_erase    = op_done && op_erase;
  assign fl_wdata    = clear_only(fl_rdata, data_q);
  assign cpu_rdata   = fl_rdata;
  assign fetch_fault = fetch_valid && scratch_hit(fetch_addr, prog_ctl[CTL_SCR], SCRATCH_BYTES);
endmodule

// File: rtl/flash_seq_checks.sv
module flash_seq_checks #(
  parameter int unsigned WRITE_CYCLES = 10000,
  parameter int unsigned ERASE_CYCLES = 2400000,
  parameter int unsigned IRQ_N        = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       prog_ctl,
  input logic             req_erase,
  input logic             busy,
  input logic             op_start,
  input logic             op_done,
  input logic             op_erase,
  input logic             fl_we,
  input logic             fl_erase,
  input logic [7:0]       fl_wdata,
  input logic [7:0]       fl_rdata,
  input logic             fetch_fault,
  input logic [IRQ_N-1:0] irq_out
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)        run <= '0;
    else if (op_start) run <= 32'd1;
    else if (busy)     run <= run + 32'd1;
  end

  a_r1_duration: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> run == (op_erase ? ERASE_CYCLES : WRITE_CYCLES));

  a_r2_commit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_erase) |=> !busy);

  a_r3_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !req_erase) |-> prog_ctl[0]);

  a_r3_erase_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && req_erase) |-> prog_ctl[1]);

  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> (fl_wdata & ~fl_rdata) == 8'h00);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_out == '0);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_start);

  a_r10_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_ctl[2] |-> !fetch_fault);
endmodule

bind flash_seq_ctrl flash_seq_checks #(
  .WRITE_CYCLES (WRITE_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES),
  .IRQ_N        (IRQ_N)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_ctl    (prog_ctl),
  .req_erase   (req_erase),
  .busy        (busy),
  .op_start    (op_start),
  .op_done     (op_done),
  .op_erase    (op_erase),
  .fl_we       (fl_we),
  .fl_erase    (fl_erase),
  .fl_wdata    (fl_wdata),
  .fl_rdata    (fl_rdata),
  .fetch_fault (fetch_fault),
  .irq_out     (irq_out)
);

// File: tb/sim_flash_seq_ctrl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctrl;
  localparam int WR = 20;
  localparam int ER = 50;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    prog_ctl = '0;
  logic          req_valid = 1'b0, req_erase = 1'b0;
  logic [15:0]   cpu_addr = '0, fetch_addr = '0, fl_addr;
  logic [7:0]    req_data = '0, cpu_rdata, fl_rdata, fl_wdata;
  logic          fetch_valid = 1'b0, fetch_fault, stall, busy, fl_scratch, fl_we, fl_erase;
  logic [NI-1:0] irq_in = '0, irq_out;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_seq_ctrl #(.WRITE_CYCLES(WR), .ERASE_CYCLES(ER), .IRQ_N(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_ctl(prog_ctl), .req_valid(req_valid),
    .req_erase(req_erase), .cpu_addr(cpu_addr), .req_data(req_data),
    .cpu_rdata(cpu_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_fault(fetch_fault), .irq_in(irq_in), .irq_out(irq_out), .stall(stall),
    .busy(busy), .fl_addr(fl_addr), .fl_scratch(fl_scratch), .fl_rdata(fl_rdata),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_erase(fl_erase));

  // Behavioural cell model: 2 KB of main array (aliased) plus the scratchpad
  logic [7:0] mem [2048];
  logic [7:0] scr [128];

  assign fl_rdata = fl_scratch ? scr[fl_addr[6:0]] : mem[fl_addr[10:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
      for (int i = 0; i < 128; i++)  scr[i] = 8'hFF;
    end else if (fl_we) begin
      if (fl_scratch) scr[fl_addr[6:0]] = fl_wdata;
      else            mem[fl_addr[10:0]] = fl_wdata;
    end else if (fl_erase) begin
      if (fl_scratch) for (int i = 0; i < 128; i++) scr[i] = 8'hFF;
      else for (int i = 0; i < 512; i++) mem[{fl_addr[10:9], 9'd0} + 11'(i)] = 8'hFF;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Issue one request at a negedge; return number of busy cycles seen
  task automatic run_op(input logic er, input logic [2:0] ctl, input logic [15:0] a,
                        input logic [7:0] d, output int n, output bit stall_bad);
    req_valid = 1'b1; req_erase = er; prog_ctl = ctl; cpu_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; stall_bad = 1'b0;
    while (busy && n < 100000) begin
      if (stall !== busy) stall_bad = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        er;
    logic [2:0]  ctl;
    logic [15:0] a;
    logic [7:0]  d;
    logic        acc;
    logic [2:0]  rctl;
    logic [15:0] ra;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b001, 16'h0105, 8'h5A, 1'b1, 3'b001, 16'h0105, 8'h5A}, // R2 write
    '{1'b0, 3'b001, 16'h0105, 8'hF0, 1'b1, 3'b001, 16'h0105, 8'h50}, // R5 AND
    '{1'b0, 3'b000, 16'h0106, 8'h00, 1'b0, 3'b001, 16'h0106, 8'hFF}, // R3 write gate
    '{1'b1, 3'b001, 16'h0150, 8'h00, 1'b0, 3'b001, 16'h0105, 8'h50}, // R3 erase gate
    '{1'b1, 3'b010, 16'h01FF, 8'h00, 1'b1, 3'b001, 16'h0105, 8'hFF}, // R4 sector erase
    '{1'b0, 3'b001, 16'h0200, 8'h33, 1'b1, 3'b001, 16'h0200, 8'h33}, // R2 second sector
    '{1'b1, 3'b010, 16'h0000, 8'h00, 1'b1, 3'b001, 16'h0200, 8'h33}, // R4 other sector kept
    '{1'b0, 3'b101, 16'h0010, 8'h12, 1'b1, 3'b100, 16'h0010, 8'h12}, // R6 scratch write
    '{1'b0, 3'b100, 16'h0011, 8'h00, 1'b0, 3'b001, 16'h0010, 8'hFF}, // R6 main under window
    '{1'b0, 3'b101, 16'h0080, 8'h44, 1'b1, 3'b001, 16'h0080, 8'h44}, // R6 above window
    '{1'b1, 3'b110, 16'h0005, 8'h00, 1'b1, 3'b100, 16'h0010, 8'hFF}, // R7 scratch erase
    '{1'b0, 3'b010, 16'h0020, 8'h00, 1'b0, 3'b100, 16'h0080, 8'h44}  // R7 main kept
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int  n;
    bit  sb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(busy === 1'b0 && stall === 1'b0, "R11 busy/stall after reset", {busy, stall}, 0);
    check(fl_we === 1'b0 && fl_erase === 1'b0, "R11 strobes after reset", {fl_we, fl_erase}, 0);
    check(irq_out === '0, "R11 irq_out after reset", irq_out, 0);

    // Table walk: R1 length, R2..R7 readback
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].er, VECS[v].ctl, VECS[v].a, VECS[v].d, n, sb);
      check(n == (VECS[v].acc ? (VECS[v].er ? ER : WR) : 0),
            $sformatf("R1/R3 busy length vector %0d", v), n,
            VECS[v].acc ? (VECS[v].er ? ER : WR) : 0);
      check(!sb, $sformatf("R1 stall tracks busy vector %0d", v), sb, 0);
      prog_ctl = VECS[v].rctl; cpu_addr = VECS[v].ra;
      #1;
      check(cpu_rdata === VECS[v].exp,
            $sformatf("R2 R3 R4 R5 R6 R7 readback vector %0d", v), cpu_rdata, VECS[v].exp);
    end

    // R6 read path mapping signals
    prog_ctl = 3'b100; cpu_addr = 16'h007F; #1;
    check(fl_scratch === 1'b1 && fl_addr === 16'h007F, "R6 window top", {fl_scratch, fl_addr}, {1'b1, 16'h007F});
    cpu_addr = 16'h0080; #1;
    check(fl_scratch === 1'b0 && fl_addr === 16'h0080, "R6 window end", {fl_scratch, fl_addr}, {1'b0, 16'h0080});

    // R8/R9: interrupts and a second request during a write
    @(negedge clk);
    irq_in = '0;
    req_valid = 1'b1; req_erase = 1'b0; prog_ctl = 3'b011; cpu_addr = 16'h0300; req_data = 8'h0F;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < WR; c++) begin
      irq_in = (c == 2) ? 4'b0010 : (c == 5) ? 4'b1000 : 4'b0000;
      req_valid = (c == 3); req_erase = 1'b1; cpu_addr = 16'h0300;
      #1;
      if (c == 2) check(irq_out === '0, "R8 irq masked while busy", irq_out, 0);
      if (c == WR - 1) check(busy === 1'b1, "R9 still busy in last cycle", busy, 1);
      @(negedge clk);
    end
    irq_in = '0; req_valid = 1'b0; req_erase = 1'b0;
    #1;
    check(busy === 1'b0, "R9 length not extended", busy, 0);
    check(irq_out === 4'b1010, "R8 held irqs released", irq_out, 4'b1010);
    @(negedge clk);
    check(busy === 1'b0, "R9 ignored erase never started", busy, 0);
    check(irq_out === 4'b0000, "R8 held irqs cleared", irq_out, 0);
    irq_in = 4'b0100; #1;
    check(irq_out === 4'b0100, "R8 pass-through when idle", irq_out, 4'b0100);
    irq_in = '0;
    prog_ctl = 3'b001; cpu_addr = 16'h0300; #1;
    check(cpu_rdata === 8'h0F, "R9 write kept, erase ignored", cpu_rdata, 8'h0F);

    // R10 fetch fault
    fetch_valid = 1'b1; prog_ctl = 3'b100; fetch_addr = 16'h0040; #1;
    check(fetch_fault === 1'b1, "R10 fetch in window", fetch_fault, 1);
    fetch_addr = 16'h0200; #1;
    check(fetch_fault === 1'b0, "R10 fetch outside window", fetch_fault, 0);
    prog_ctl = 3'b000; fetch_addr = 16'h0040; #1;
    check(fetch_fault === 1'b0, "R10 window disabled", fetch_fault, 0);
    fetch_valid = 1'b0; prog_ctl = 3'b100; #1;
    check(fetch_fault === 1'b0, "R10 no fetch", fetch_fault, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule